// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Counter

This block keeps the time of day on a twelve-hour dial. A one-cycle pulse, once per second, advances a chain of synchronous decimal counters on the common clock. The chain has a seconds stage and a minutes stage, each counting 00 to 59, and an hours stage that runs 12, 1, 2 and so on up to 11, then back to 12. A morning/afternoon flag flips each time the hours stage moves from 11 to 12.

Every digit is presented as packed BCD, with the least significant bit at index 0. A later stage moves only in a cycle where the pulse is high and every earlier stage stands at its final value. Synchronous reset puts the clock at 12:00:00 in the morning half. Setting the time and driving a display are left to surrounding logic.

Top module: `tod12_clock`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge read 12:00:00 with `pm` = 0 (`hr_tens` = 1, `hr_ones` = 2, all other digits 0).
- R2: Each cycle with `tick` high advances `sec_ones` by one. From 9 it returns to 0 and `sec_tens` goes up by one in the same edge.
- R3: `sec_tens` stays within 0 to 5 and every units digit stays within 0 to 9. From 59, a tick returns seconds to 00.
- R4: In a cycle with `tick` low, no output changes.
- R5: The minute digits change only at the edge where `tick` is high and seconds read 59. They then count 00 to 59 like the seconds do.
- R6: At a tick with minutes and seconds both at 59, minutes and seconds go to 00 and the hours stage advances by one.
- R7: From hour 12, the hours stage goes to 1 (`hr_tens` = 0, `hr_ones` = 1) and never shows 0 or 13.
- R8: `hr_tens` is 1 only for hours 10, 11 and 12. Hour 9 is followed by hour 10.
- R9: `pm` inverts exactly when the hours go from 11 to 12, and at no other time.
- R10: 43200 ticks (3600 ticks per hour, times 12) bring the digits back to their starting value with `pm` inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| rst | input | 1 | Synchronous active-high reset to 12:00:00 AM |
| tick | input | 1 | One-cycle pulse that advances the time by one second |
| hr_tens | output | 1 | Hours tens digit (0 or 1) |
| hr_ones | output | 4 | Hours units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD 0..5 |
| min_ones | output | 4 | Minutes units digit, BCD 0..9 |
| sec_tens | output | 4 | Seconds tens digit, BCD 0..5 |
| sec_ones | output | 4 | Seconds units digit, BCD 0..9 |
| pm | output | 1 | 0 for the morning half, 1 for the afternoon half |

## Verification
Several rollovers can fall on one edge. At 11:59:59 a single tick wraps seconds, wraps minutes, moves the hours from 11 to 12 and inverts `pm`. At 12:59:59 it wraps all three stages and the hours go to 1. The bench drives more than 24 hours of ticks back to back, so each of these combined edges happens twice. It compares every digit and the flag against a model that counts total seconds. Ticks are held off at chosen 59-second points to show that a carry waiting at a terminal count moves nothing until the pulse arrives.

// File: rtl/tod12_pkg.sv
package tod12_pkg;

    localparam int DIGIT_W   = 4;
    localparam int UNITS_MOD = 10;
    localparam int TENS_MOD  = 6;
    localparam int NUM_SIXTY = 2;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        logic tens;
        bcd_t ones;
        logic pm;
    } hour_t;

    localparam hour_t HOUR_RESET = '{tens: 1'b1, ones: bcd_t'(2), pm: 1'b0};

    // Advance the hours dial by one position: 12 -> 1, 9 -> 10, 11 -> 12 flips the half.
    function automatic hour_t hour_step(hour_t h);
        hour_t n;
        n = h;
        if (h.tens && h.ones == bcd_t'(2)) begin
            n.tens = 1'b0;
            n.ones = bcd_t'(1);
        end else if (!h.tens && h.ones == bcd_t'(9)) begin
            n.tens = 1'b1;
            n.ones = '0;
        end else if (h.tens && h.ones == bcd_t'(1)) begin
            n.ones = bcd_t'(2);
            n.pm   = ~h.pm;
        end else begin
            n.ones = h.ones + bcd_t'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
    import tod12_pkg::*;
#(
    parameter int MOD = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output bcd_t q,
    output logic last
);
    localparam bcd_t LAST_VAL = bcd_t'(MOD - 1);

    assign last = (q == LAST_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= last ? '0 : q + bcd_t'(1);
        end
    end
endmodule

// File: rtl/sixty_stage.sv
module sixty_stage
    import tod12_pkg::*;
#(
    parameter int LOW_MOD  = UNITS_MOD,
    parameter int HIGH_MOD = TENS_MOD
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output bcd_t tens,
    output bcd_t ones,
    output logic carry
);
    logic ones_last;
    logic tens_last;

    bcd_digit #(.MOD(LOW_MOD)) u_ones (
        .clk(clk), .rst(rst), .en(en), .q(ones), .last(ones_last)
    );

    bcd_digit #(.MOD(HIGH_MOD)) u_tens (
        .clk(clk), .rst(rst), .en(en & ones_last), .q(tens), .last(tens_last)
    );

    assign carry = en & ones_last & tens_last;
endmodule

// File: rtl/hour_stage.sv
module hour_stage
    import tod12_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    output hour_t hr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hr <= HOUR_RESET;
        end else if (en) begin
            hr <= hour_step(hr);
        end
    end
endmodule

// File: rtl/tod12_clock.sv
module tod12_clock
    import tod12_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic             hr_tens,
    output logic [DIGIT_W-1:0] hr_ones,
    output logic [DIGIT_W-1:0] min_tens,
    output logic [DIGIT_W-1:0] min_ones,
    output logic [DIGIT_W-1:0] sec_tens,
    output logic [DIGIT_W-1:0] sec_ones,
    output logic             pm
);
    logic [NUM_SIXTY:0] chain;
    bcd_t               st_tens [NUM_SIXTY];
    bcd_t               st_ones [NUM_SIXTY];
    hour_t              hr;

    assign chain[0] = tick;

    // Stage 0 is seconds, stage 1 is minutes.
    generate
        for (genvar i = 0; i < NUM_SIXTY; i++) begin : g_sixty
            sixty_stage #(.LOW_MOD(UNITS_MOD), .HIGH_MOD(TENS_MOD)) u_stage (
                .clk(clk), .rst(rst), .en(chain[i]),
                .tens(st_tens[i]), .ones(st_ones[i]), .carry(chain[i+1])
            );
        end
    endgenerate

    hour_stage u_hours (
        .clk(clk), .rst(rst), .en(chain[NUM_SIXTY]), .hr(hr)
    );

    assign sec_ones = st_ones[0];
    assign sec_tens = st_tens[0];
    assign min_ones = st_ones[1];
    assign min_tens = st_tens[1];
    assign hr_ones  = hr.ones;
    assign hr_tens  = hr.tens;
    assign pm       = hr.pm;
endmodule

// File: rtl/tod12_clock_chk.sv
module tod12_clock_chk
    import tod12_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input logic hr_tens,
    input bcd_t hr_ones,
    input bcd_t min_tens,
    input bcd_t min_ones,
    input bcd_t sec_tens,
    input bcd_t sec_ones,
    input logic pm
);
    logic sec59, min59;
    assign sec59 = (sec_tens == bcd_t'(5)) && (sec_ones == bcd_t'(9));
    assign min59 = (min_tens == bcd_t'(5)) && (min_ones == bcd_t'(9));

    // R1
    reset_value_chk: assert property (@(posedge clk)
        rst |=> (hr_tens && hr_ones == bcd_t'(2) && min_tens == '0 && min_ones == '0
                 && sec_tens == '0 && sec_ones == '0 && !pm));

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tens <= bcd_t'(5) && min_tens <= bcd_t'(5)
         && sec_ones <= bcd_t'(9) && min_ones <= bcd_t'(9)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(sec_ones) && $stable(sec_tens) && $stable(min_ones)
                   && $stable(min_tens) && $stable(hr_ones) && $stable(hr_tens) && $stable(pm)));

    // R5
    min_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && min_ones != $past(min_ones)) |-> ($past(tick) && $past(sec59)));

    // R7
    hour_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && sec59 && min59 && hr_tens && hr_ones == bcd_t'(2))
        |=> (!hr_tens && hr_ones == bcd_t'(1)));

    // R8
    hour_range_chk: assert property (@(posedge clk) disable iff (rst)
        hr_tens ? (hr_ones <= bcd_t'(2)) : (hr_ones >= bcd_t'(1) && hr_ones <= bcd_t'(9)));

    // R9
    half_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pm != $past(pm))
        |-> (hr_tens && hr_ones == bcd_t'(2) && min_tens == '0 && min_ones == '0
             && sec_tens == '0 && sec_ones == '0));
endmodule

bind tod12_clock tod12_clock_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .hr_tens(hr_tens), .hr_ones(hr_ones),
    .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens),
    .sec_ones(sec_ones), .pm(pm)
);

// File: tb/tod12_clock_tb.sv
`timescale 1ns/1ps
module tod12_clock_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       hr_tens, pm;
    logic [3:0] hr_ones, min_tens, min_ones, sec_tens, sec_ones;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        int    h;
        int    m;
        int    s;
        bit    half;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    int model_secs = 0;   // seconds since 12:00:00, 0..43199
    bit model_pm   = 0;
    int ticks_sent = 0;

    always #5 clk = ~clk;

    tod12_clock u_dut (
        .clk(clk), .rst(rst), .tick(tick), .hr_tens(hr_tens), .hr_ones(hr_ones),
        .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens),
        .sec_ones(sec_ones), .pm(pm)
    );

    function automatic int disp_hour(int secs);
        int hh;
        hh = secs / 3600;
        return (hh == 0) ? 12 : hh;
    endfunction

    task automatic compare(string tag, int eh, int em, int es, bit epm);
        int ah, am, as_;
        ah  = hr_tens * 10 + hr_ones;
        am  = min_tens * 10 + min_ones;
        as_ = sec_tens * 10 + sec_ones;
        n_run++;
        if (ah != eh || am != em || as_ != es || pm != epm || min_ones > 9 || sec_ones > 9) begin
            n_fail++;
            $display("FAIL %s: got %0d:%0d:%0d pm=%0d (raw %0d %0d %0d %0d %0d %0d) expected %0d:%0d:%0d pm=%0d",
                     tag, ah, am, as_, pm, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones,
                     eh, em, es, epm);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(bit t);
        exp_t e;
        string tg;
        @(negedge clk);
        tick = t;
        if (t) begin
            model_secs = model_secs + 1;
            ticks_sent++;
            if (model_secs == 43200) begin
                model_secs = 0;
                model_pm   = ~model_pm;
                tg = "R9";
            end else if (model_secs % 3600 == 0) begin
                if (disp_hour(model_secs) == 1)       tg = "R7";
                else if (disp_hour(model_secs) == 10) tg = "R8";
                else                                  tg = "R6";
            end else if (model_secs % 60 == 0) begin
                tg = "R5";
            end else if (model_secs % 10 == 0) begin
                tg = "R3";
            end else begin
                tg = "R2";
            end
        end else begin
            tg = "R4";
        end
        e.h = disp_hour(model_secs);
        e.m = (model_secs / 60) % 60;
        e.s = model_secs % 60;
        e.half = model_pm;
        e.tag = tg;
        exp_q.push_back(e);
    endtask

    // Monitor: after each edge, compare the outputs with the oldest queued item.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compare(e.tag, e.h, e.m, e.s, e.half);
        end
    end

    task automatic run_half_day();
        for (int k = 0; k < 43200; k++) begin
            // Hold the pulse off at :59 seconds in the first hour and at every 59:59.
            if (model_secs % 60 == 59 && (ticks_sent < 3600 || model_secs % 3600 == 3599)) begin
                step(1'b0);
                step(1'b0);
            end
            step(1'b1);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        tick = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        tick = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset dominates a pending tick
        compare("R1", 12, 0, 0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        tick = 1'b0;
        run_half_day();
        drain();
        // R10: one half-day returns to 12:00:00 with the flag inverted
        compare("R10", 12, 0, 0, 1'b1);
        run_half_day();
        drain();
        // R10: a second half-day restores the morning flag
        compare("R10", 12, 0, 0, 1'b0);
        // Advance a little, then reset again mid-count.
        repeat (75) step(1'b1);
        drain();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        compare("R1", 12, 0, 0, 1'b0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule